// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block generates the access address for one port of a clocked memory and contains a small single-port RAM model that the address drives. On every clock edge it chooses one of four internal addresses. It can use the external address, an incremented copy of the previous internal address, the previous internal address unchanged, or an address saved earlier. The block keeps the address from the last external load so that a burst can be sent back to its start with no idle cycle in between.

The control inputs are active-low: an address strobe, a count enable and a repeat. The RAM takes an active-low chip enable, a read/write select (high means read) and active-low byte enables. The `PIPELINED` parameter selects flow-through or pipelined read timing. A typical burst looks like this:

- Load An and write.
- Advance and write An+1.
- Advance and write An+2.
- Hold and write An+2 again.
- Repeat and write An.

Top module: `burst_counter_mem`

## Requirements
- R1: With `repeatN` high and `addrStrobeN` low, `memAddr` equals `extAddr` in that cycle, whatever `countEnN` is. The same value is saved as the repeat address.
- R2: With `repeatN` and `addrStrobeN` high and `countEnN` low, `memAddr` is one more than the previous cycle's `memAddr`.
- R3: With `repeatN`, `addrStrobeN` and `countEnN` all high, `memAddr` equals the previous cycle's `memAddr`.
- R4: With `repeatN` low, `memAddr` equals the address saved at the most recent strobe load. Repeat overrides the strobe. A strobe given in a repeat cycle neither changes `memAddr` nor updates the saved address.
- R5: A repeat costs no idle cycle. A read or write issued in the repeat cycle accesses the reloaded address.
- R6: A write happens only when `chipEnN` and `readWrite` are both low. Byte lane i is `wrData[8i+7:8i]`, and it is written only when `byteEnN[i]` is 0. A disabled lane keeps its stored value. With `chipEnN` high, nothing is written.
- R7: With `PIPELINED`=0, read data for a read sampled at a clock edge is on `rdData` from that edge until the next read.
- R8: With `PIPELINED`=1, read data appears one clock later than with `PIPELINED`=0.
- R9: After reset, the internal counter and the saved repeat address are zero and `rdData` is zero.
- R10: Advancing from the top address (all ones) gives address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEnN | input | 1 | Active-low enable for the access |
| readWrite | input | 1 | 1 = read, 0 = write |
| addrStrobeN | input | 1 | Active-low load of the external address |
| countEnN | input | 1 | Active-low counter advance |
| repeatN | input | 1 | Active-low reload of the saved address |
| byteEnN | input | BYTES | Active-low byte lane write enables |
| extAddr | input | ADDR_W | External address |
| wrData | input | 8*BYTES | Write data |
| rdData | output | 8*BYTES | Read data (flow-through or pipelined) |
| memAddr | output | ADDR_W | Internal address used for the access in this cycle |

## Verification
The assertions assume that the control inputs are stable and known across each rising edge. They also assume that a read is only compared against addresses that were written earlier, because the RAM model has no reset.

The bench changes every input only at the falling edge. It writes each location before reading it back. Both read timings are checked by running a flow-through instance and a pipelined instance side by side on the same stimulus.

// File: rtl/burst_mem_pkg.sv
package burst_mem_pkg;
  // Decoded per-cycle strobes from control to the datapath
  typedef struct packed {
    logic useSaved;  // repeat reload
    logic useExt;    // external address load
    logic bump;      // counter advance
    logic wrEn;      // write access
    logic rdEn;      // read access
  } ctrlStrobes_t;
endpackage

// File: rtl/burst_mem_ctrl.sv
module burst_mem_ctrl
  import burst_mem_pkg::*;
(
  input  logic         chipEnN,
  input  logic         readWrite,
  input  logic         addrStrobeN,
  input  logic         countEnN,
  input  logic         repeatN,
  output ctrlStrobes_t strb
);
  // Priority: repeat, then strobe, then count enable
  always_comb begin
    strb.useSaved = !repeatN;
    strb.useExt   = repeatN && !addrStrobeN;
    strb.bump     = repeatN && addrStrobeN && !countEnN;
    strb.wrEn     = !chipEnN && !readWrite;
    strb.rdEn     = !chipEnN && readWrite;
  end
endmodule

// File: rtl/burst_mem_addr.sv
module burst_mem_addr
  import burst_mem_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] memAddr
);
  logic [ADDR_W-1:0] countReg;
  logic [ADDR_W-1:0] savedReg;

  always_comb begin
    if (strb.useSaved)    memAddr = savedReg;
    else if (strb.useExt) memAddr = extAddr;
    else if (strb.bump)   memAddr = countReg + ADDR_W'(1);
    else                  memAddr = countReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      savedReg <= '0;
    end else begin
      countReg <= memAddr;
      if (strb.useExt) savedReg <= extAddr;
    end
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.useExt |=> (countReg == $past(extAddr)) && (savedReg == $past(extAddr)));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.bump |=> countReg == $past(countReg) + ADDR_W'(1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.useSaved && !strb.useExt && !strb.bump) |=> $stable(countReg));

  assert_repeat_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.useSaved |=> (countReg == $past(savedReg)) && $stable(savedReg));
endmodule

// File: rtl/burst_mem_array.sv
module burst_mem_array
  import burst_mem_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BYTES     = 2,
  parameter bit PIPELINED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic [BYTES-1:0]     byteEnN,
  input  logic [8*BYTES-1:0]   wrData,
  output logic [8*BYTES-1:0]   rdData
);
  localparam int DATA_W = 8 * BYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] flowReg;

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int i = 0; i < BYTES; i++) begin
        if (!byteEnN[i]) mem[memAddr][8*i +: 8] <= wrData[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          flowReg <= '0;
    else if (strb.rdEn) flowReg <= mem[memAddr];
  end

  assert_flow_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> flowReg == $past(mem[memAddr]));

  generate
    if (PIPELINED) begin : g_pipe
      logic [DATA_W-1:0] pipeReg;
      always_ff @(posedge clk) begin
        if (!rstN) pipeReg <= '0;
        else       pipeReg <= flowReg;
      end
      assign rdData = pipeReg;

      assert_pipe_R8: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> pipeReg == $past(flowReg));
    end else begin : g_flow
      assign rdData = flowReg;
    end
  endgenerate
endmodule

// File: rtl/burst_counter_mem.sv
module burst_counter_mem
  import burst_mem_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BYTES     = 2,
  parameter bit PIPELINED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipEnN,
  input  logic                 readWrite,
  input  logic                 addrStrobeN,
  input  logic                 countEnN,
  input  logic                 repeatN,
  input  logic [BYTES-1:0]     byteEnN,
  input  logic [ADDR_W-1:0]    extAddr,
  input  logic [8*BYTES-1:0]   wrData,
  output logic [8*BYTES-1:0]   rdData,
  output logic [ADDR_W-1:0]    memAddr
);
  ctrlStrobes_t strb;

  burst_mem_ctrl uCtrl (
    .chipEnN(chipEnN), .readWrite(readWrite), .addrStrobeN(addrStrobeN),
    .countEnN(countEnN), .repeatN(repeatN), .strb(strb)
  );

  burst_mem_addr #(.ADDR_W(ADDR_W)) uAddr (
    .clk(clk), .rstN(rstN), .strb(strb), .extAddr(extAddr), .memAddr(memAddr)
  );

  burst_mem_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .PIPELINED(PIPELINED)) uArray (
    .clk(clk), .rstN(rstN), .strb(strb), .memAddr(memAddr),
    .byteEnN(byteEnN), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/tb_burst_counter_mem.sv
`timescale 1ns/1ps
module tb_burst_counter_mem;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 8 * NB;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, chipEnN = 1'b1, readWrite = 1'b1;
  logic addrStrobeN = 1'b1, countEnN = 1'b1, repeatN = 1'b1;
  logic [NB-1:0] byteEnN = '1;
  logic [AW-1:0] extAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdFlow, rdPipe;
  logic [AW-1:0] memAddr, memAddrPipe;

  burst_counter_mem #(.ADDR_W(AW), .BYTES(NB), .PIPELINED(1'b0)) dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .readWrite(readWrite),
    .addrStrobeN(addrStrobeN), .countEnN(countEnN), .repeatN(repeatN),
    .byteEnN(byteEnN), .extAddr(extAddr), .wrData(wrData),
    .rdData(rdFlow), .memAddr(memAddr));

  burst_counter_mem #(.ADDR_W(AW), .BYTES(NB), .PIPELINED(1'b1)) dutPipe (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .readWrite(readWrite),
    .addrStrobeN(addrStrobeN), .countEnN(countEnN), .repeatN(repeatN),
    .byteEnN(byteEnN), .extAddr(extAddr), .wrData(wrData),
    .rdData(rdPipe), .memAddr(memAddrPipe));

  int errors = 0, checks = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; logic [DW-1:0] data; bit pipe; string tag; } item_t;
  item_t scoreQ[$];
  logic [DW-1:0] refMem [64];
  logic [AW-1:0] refCount = '0, refSaved = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle, check the address, queue expected read data
  task automatic step(input bit rpt, input bit ads, input bit cnt, input bit ce,
                      input bit rw, input logic [NB-1:0] be, input logic [AW-1:0] ea,
                      input logic [DW-1:0] wd, input string tag);
    logic [AW-1:0] a;
    @(negedge clk);
    repeatN = rpt; addrStrobeN = ads; countEnN = cnt; chipEnN = ce;
    readWrite = rw; byteEnN = be; extAddr = ea; wrData = wd;
    if (!rpt)      a = refSaved;
    else if (!ads) begin a = ea; refSaved = ea; end
    else if (!cnt) a = refCount + AW'(1);
    else           a = refCount;
    #1;
    check({tag, " addr"}, 32'(memAddr), 32'(a));
    check({tag, " addrPipe"}, 32'(memAddrPipe), 32'(a));
    refCount = a;
    if (!ce && !rw)
      for (int i = 0; i < NB; i++) if (!be[i]) refMem[a][8*i +: 8] = wd[8*i +: 8];
    if (!ce && rw) begin
      scoreQ.push_back('{cyc + 1, refMem[a], 1'b0, {tag, " flow R7"}});
      scoreQ.push_back('{cyc + 2, refMem[a], 1'b1, {tag, " pipe R8"}});
    end
  endtask

  // Monitor: compare read data when due
  always @(negedge clk) begin
    while (scoreQ.size() > 0 && scoreQ[0].due <= cyc) begin
      item_t it;
      it = scoreQ.pop_front();
      if (it.due < cyc) check({it.tag, " missed"}, 32'(it.due), 32'(cyc));
      else check(it.tag, 32'(it.pipe ? rdPipe : rdFlow), 32'(it.data));
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R9 rdFlow", 32'(rdFlow), 0);
    check("R9 rdPipe", 32'(rdPipe), 0);
    step(1,1,1,1,1,'1,6'd9,0,"R9 counter zero");
    step(0,1,1,1,1,'1,6'd9,0,"R9 saved zero");
    // burst write: load, advance, advance, hold, repeat
    step(1,0,1,0,0,2'b00,6'd5,16'h1111,"R1 load write");
    step(1,1,0,0,0,2'b00,6'd0,16'h2222,"R2 advance write");
    step(1,1,0,0,0,2'b00,6'd0,16'h3333,"R2 advance write2");
    step(1,1,1,0,0,2'b00,6'd0,16'h4444,"R3 hold write");
    step(0,1,1,0,0,2'b00,6'd0,16'h5555,"R5 repeat write");
    // burst read back
    step(1,0,1,0,1,'1,6'd5,0,"R1 load read");
    step(1,1,0,0,1,'1,6'd0,0,"R2 advance read");
    step(1,1,0,0,1,'1,6'd0,0,"R2 advance read2");
    step(1,1,1,0,1,'1,6'd0,0,"R3 hold read");
    step(0,1,1,0,1,'1,6'd0,0,"R5 repeat read");
    // byte lanes and chip enable
    step(1,0,1,0,0,2'b00,6'd10,16'hAAAA,"R6 full write");
    step(1,1,1,0,0,2'b10,6'd0,16'h1234,"R6 lane0 write");
    step(1,1,1,0,1,'1,6'd0,0,"R6 lane read");
    step(1,1,1,1,0,2'b00,6'd0,16'hFFFF,"R6 disabled write");
    step(1,1,1,0,1,'1,6'd0,0,"R6 after disabled");
    step(1,1,1,0,0,2'b01,6'd0,16'h5678,"R6 lane1 write");
    step(1,1,1,0,1,'1,6'd0,0,"R6 lane1 read");
    // strobe beats count enable; repeat beats strobe
    step(1,0,0,1,1,'1,6'd20,0,"R1 strobe over count");
    step(0,0,0,1,1,'1,6'd33,0,"R4 repeat over strobe");
    step(1,1,0,1,1,'1,6'd0,0,"R2 advance after repeat");
    step(0,1,1,1,1,'1,6'd0,0,"R4 saved unchanged");
    // wrap at top address
    step(1,0,1,0,0,2'b00,6'd63,16'hBEEF,"R10 load top");
    step(1,1,0,0,0,2'b00,6'd0,16'hCAFE,"R10 wrap write");
    step(1,0,1,0,1,'1,6'd0,0,"R10 read zero");
    step(0,1,1,0,1,'1,6'd0,0,"R5 repeat read zero");
    repeat (4) step(1,1,1,1,1,'1,6'd0,0,"R3 idle");
    finishRun();
  end
endmodule